// File: doc/BRIEF.md
# Framed I/Q Serial Output Port

This block sends complex receiver samples out over a synchronous serial link, one sample pair per frame. Each frame carries the I word and then the Q word, both MSB first. The word length can be 12, 16 or 24 bits. The block takes 24-bit, MSB-justified I and Q words on a one-cycle valid strobe. It holds the most recent pair until the next frame begins.

The port runs in one of two modes:

- **Clock master.** It divides the system clock to make the serial clock and drives a frame sync. The frame sync takes one of three shapes: a single pulse before the frame, a level held high for the whole frame, or one pulse before each word.
- **Slave.** It oversamples an external serial clock and frame sync with the system clock. It runs all of its shifting from those two signals.

In both modes, a one-period end-of-frame strobe follows the last Q bit. Several ports can share one serial clock in a daisy chain, with each port's strobe wired to the next port's frame sync input. All configuration inputs are expected to be static while the port is out of reset.

Top module: `iq_serial_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `sclk_out`, `fs_out`, `sdo` and `fe_out` are all 0.
- R2: In master mode, `sclk_out` starts low after reset and toggles every `cfg_div`+1 system clock cycles, so one serial period is 2·(`cfg_div`+1) cycles.
- R3: Word length is chosen by `cfg_wlen`: 2'b00 gives 12 bits, 2'b01 gives 16 bits, and 2'b10 or 2'b11 gives 24 bits. The bits sent are the top N bits of each 24-bit input word, so bit 23 goes first.
- R4: The data bits of a frame are I[23] down to I[24-N], then Q[23] down to Q[24-N], one bit per serial period. In master mode, `sdo` and `fs_out` change only in the system clock cycle in which `sclk_out` rises.
- R5: With `cfg_fsm` = 2'b00, `fs_out` is high for exactly the one serial period before the period that carries I[23].
- R6: With `cfg_fsm` = 2'b01, `fs_out` is high from the period before I[23] through the period that carries the last Q bit, and low in the period after.
- R7: With `cfg_fsm` = 2'b10 or 2'b11, `fs_out` is high in the period before I[23] and again in the period that carries the last I bit, which is the period before Q[23]. It is low in all other periods.
- R8: `fe_out` is high for exactly the one serial period after the last Q bit. `sdo` is 0 in every period that carries no data bit.
- R9: In master mode, a frame sync is issued at the first serial clock rise at which a sample is pending and no frame is in progress. Back-to-back frames are possible: the next frame sync can coincide with the rise that ends the end-of-frame strobe.
- R10: A pair is taken into the shift register only at frame start. If several pairs arrive during a frame, only the latest is kept and sent in the next frame. When no pair is pending, no frame starts.
- R11: In slave mode, a frame starts at a synchronized `sclk_in` rise at which `fs_in` is high, a sample is pending and no frame is in progress. That same rise presents I[23]. `fs_in` has no effect during a frame or when no sample is pending.
- R12: `cfg_master` = 1 selects master mode. `cfg_master` = 0 selects slave mode, in which `sclk_out` and `fs_out` stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_div | input | 4 | Serial clock half-period minus one, in system clocks |
| cfg_wlen | input | 2 | Word length select |
| cfg_fsm | input | 2 | Frame-sync shape in master mode |
| smp_valid | input | 1 | One-cycle strobe that presents a new I/Q pair |
| smp_i | input | 24 | I word, MSB-justified |
| smp_q | input | 24 | Q word, MSB-justified |
| sclk_in | input | 1 | External serial clock (slave mode) |
| fs_in | input | 1 | External frame sync (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| sdo | output | 1 | Serial data |
| fe_out | output | 1 | End-of-frame strobe |

## Verification
A bit counter or mask that is off shows up inside the first frame after a sample arrives. It appears as a shifted or truncated bit stream, a frame sync in the wrong period, or an end-of-frame strobe one period early or late, all within 2·N+3 serial periods. A stuck pending flag shows at the ports as a missing frame, or as an extra frame after the last sample, one strobe period after the previous frame ends. A wrong divider count appears at the first serial clock edge as a wrong half-period. Slave-mode errors show up either as a frame that starts without a pending sample or one that ignores a valid frame sync; both show on `sdo` at the next synchronized serial clock rise.

// File: rtl/iq_serial_tx.sv
`timescale 1ns/1ps
module iq_serial_tx #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic [3:0]    cfg_div,
  input  logic [1:0]    cfg_wlen,
  input  logic [1:0]    cfg_fsm,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_i,
  input  logic [SW-1:0] smp_q,
  input  logic          sclk_in,
  input  logic          fs_in,
  output logic          sclk_out,
  output logic          fs_out,
  output logic          sdo,
  output logic          fe_out
);
  localparam int FW = 2*SW;
  localparam int BW = $clog2(FW);

  logic [3:0]    cnt;
  logic          sclk_q, fs_q, fe_q, sdo_q;
  logic          act, armed, pend;
  logic [BW-1:0] bidx, nbits, last_idx;
  logic [FW-1:0] sh, frame_w;
  logic [SW-1:0] hold_i, hold_q, mask;
  logic [2:0]    s_ck;
  logic [1:0]    s_fs;
  logic          rise, last_bit, arm_now, start;

  assign nbits    = (cfg_wlen == 2'b00) ? BW'(12) : (cfg_wlen == 2'b01) ? BW'(16) : BW'(24);
  assign last_idx = {nbits[BW-2:0], 1'b0} - BW'(1);
  assign mask     = ~({SW{1'b1}} >> nbits);
  assign frame_w  = {hold_i & mask, {SW{1'b0}}} | ({hold_q & mask, {SW{1'b0}}} >> nbits);

  assign rise     = cfg_master ? (cnt == cfg_div && !sclk_q) : (s_ck[1] && !s_ck[2]);
  assign last_bit = act && bidx == last_idx;
  assign arm_now  = cfg_master && rise && !act && !armed && pend;
  assign start    = rise && !act && (cfg_master ? armed : (s_fs[1] && pend));

  // serial clock divider (master) and input synchronizers (slave)
  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_master) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (cnt == cfg_div) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ck <= '0;
      s_fs <= '0;
    end else begin
      s_ck <= {s_ck[1:0], sclk_in};
      s_fs <= {s_fs[0], fs_in};
    end
  end

  // pending sample holding
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
    end else if (smp_valid) begin
      pend   <= 1'b1;
      hold_i <= smp_i;
      hold_q <= smp_q;
    end else if (start) begin
      pend   <= 1'b0;
    end
  end

  // frame sequencing, one step per serial clock rise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      armed <= 1'b0;
      bidx  <= '0;
      sh    <= '0;
      sdo_q <= 1'b0;
      fe_q  <= 1'b0;
      fs_q  <= 1'b0;
    end else if (rise) begin
      fe_q <= last_bit;
      if (start) begin
        act   <= 1'b1;
        armed <= 1'b0;
        bidx  <= '0;
        sdo_q <= frame_w[FW-1];
        sh    <= frame_w << 1;
      end else if (last_bit) begin
        act   <= 1'b0;
        sdo_q <= 1'b0;
      end else if (act) begin
        bidx  <= bidx + BW'(1);
        sdo_q <= sh[FW-1];
        sh    <= sh << 1;
      end
      if (arm_now) armed <= 1'b1;
      fs_q <= cfg_master && (arm_now
              || (cfg_fsm == 2'b01 && (start || (act && !last_bit)))
              || (cfg_fsm[1] && act && bidx == nbits - BW'(2)));
    end
  end

  assign sclk_out = sclk_q;
  assign fs_out   = fs_q;
  assign sdo      = sdo_q;
  assign fe_out   = fe_q;
endmodule

// File: rtl/iq_serial_tx_chk.sv
`timescale 1ns/1ps
module iq_serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_master,
  input logic [3:0] cfg_div,
  input logic [1:0] cfg_fsm,
  input logic       sclk_out,
  input logic       fs_out,
  input logic       sdo,
  input logic       fe_out
);
  logic [4:0] hc;
  logic       psc, seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc   <= '0;
      psc  <= 1'b0;
      seen <= 1'b0;
    end else begin
      psc <= sclk_out;
      if (sclk_out != psc) begin
        hc   <= '0;
        seen <= 1'b1;
      end else if (hc != 5'h1f) begin
        hc <= hc + 5'd1;
      end
    end
  end

  p_sclk_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && seen && sclk_out != psc) |-> hc == {1'b0, cfg_div});

  p_slave_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && $past(!cfg_master)) |-> (!sclk_out && !fs_out));

  p_change_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && (!$stable(sdo) || !$stable(fs_out))) |-> $rose(sclk_out));

  p_fe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fe_out |-> !sdo);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_fsm == 2'b00 && $past(fs_out) && $rose(sclk_out)) |-> !fs_out);
endmodule

bind iq_serial_tx iq_serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
  .cfg_fsm(cfg_fsm), .sclk_out(sclk_out), .fs_out(fs_out), .sdo(sdo), .fe_out(fe_out)
);

// File: tb/tb_iq_serial_tx.sv
`timescale 1ns/1ps
module tb_iq_serial_tx;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, cfg_master = 1'b1, smp_valid = 1'b0, sclk_in = 1'b0, fs_in = 1'b0;
  logic [3:0] cfg_div = '0;
  logic [1:0] cfg_wlen = '0, cfg_fsm = '0;
  logic [23:0] smp_i = '0, smp_q = '0;
  logic sclk_out, fs_out, sdo, fe_out;

  iq_serial_tx dut (.*);

  int nchk = 0, nfail = 0, cyc = 0, nrec = 0;
  logic rec_fs [0:8191];
  logic rec_sd [0:8191];
  logic rec_fe [0:8191];
  int   rec_t  [0:8191];
  logic pm = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (sclk_out && !pm && nrec < 8192) begin
      rec_fs[nrec] = fs_out; rec_sd[nrec] = sdo; rec_fe[nrec] = fe_out; rec_t[nrec] = cyc;
      nrec++;
    end
    pm = sclk_out;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog R9: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] wl);
    return (wl == 2'b00) ? 12 : (wl == 2'b01) ? 16 : 24;
  endfunction

  function automatic logic [47:0] exp_seq(input logic [23:0] i, input logic [23:0] q, input int n);
    logic [47:0] e = '0;
    for (int j = 0; j < 2*n; j++) e[j] = (j < n) ? i[23-j] : q[23-(j-n)];
    return e;
  endfunction

  function automatic logic [47:0] grab(input int at, input int n);
    logic [47:0] g = '0;
    for (int j = 0; j < 2*n; j++) g[j] = rec_sd[at+j];
    return g;
  endfunction

  task automatic do_reset(input logic m, input logic [3:0] d, input logic [1:0] wl, input logic [1:0] fsm);
    @(negedge clk);
    rst_n = 1'b0; cfg_master = m; cfg_div = d; cfg_wlen = wl; cfg_fsm = fsm;
    sclk_in = 1'b0; fs_in = 1'b0; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [23:0] i, input logic [23:0] q);
    @(negedge clk);
    smp_i = i; smp_q = q; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_rec(input int target);
    while (nrec < target) @(negedge clk);
  endtask

  function automatic int find_fs(input int base);
    for (int k = base; k < base + 4; k++) if (rec_fs[k]) return k;
    return -1;
  endfunction

  task automatic master_frame(input logic [23:0] i, input logic [23:0] q,
                              input logic [1:0] wl, input logic [1:0] fsm, input logic [3:0] dv);
    int n, base, f;
    logic [63:0] afs, efs, afe, efe;
    logic [2:0] az;
    string ftag;
    n = wbits(wl);
    do_reset(1'b1, dv, wl, fsm);
    base = nrec;
    send(i, q);
    wait_rec(base + 2*n + 8);
    f = find_fs(base);
    check(f >= 0, "R9 frame sync after sample", 64'(f), 64'(base));
    if (f < 0) return;
    afs = '0; efs = '0; afe = '0; efe = '0;
    for (int k = 0; k <= 2*n+1; k++) begin afs[k] = rec_fs[f+k]; afe[k] = rec_fe[f+k]; end
    efs[0] = 1'b1;
    if (fsm == 2'b01) for (int k = 1; k <= 2*n; k++) efs[k] = 1'b1;
    if (fsm[1]) efs[n] = 1'b1;
    efe[2*n+1] = 1'b1;
    az = {rec_sd[f+2*n+2], rec_sd[f+2*n+1], rec_sd[f]};
    ftag = (fsm == 2'b00) ? "R5 single sync" : (fsm == 2'b01) ? "R6 held sync" : "R7 split sync";
    check(grab(f+1, n) == exp_seq(i, q, n), "R3 R4 data bits", 64'(grab(f+1, n)), 64'(exp_seq(i, q, n)));
    check(afs == efs, ftag, afs, efs);
    check(afe == efe, "R8 end strobe", afe, efe);
    check(az == 3'b000, "R8 idle data zero", 64'(az), 64'd0);
    check(rec_t[f+1] - rec_t[f] == 2*(int'(dv)+1), "R2 R12 serial period",
          64'(rec_t[f+1] - rec_t[f]), 64'(2*(int'(dv)+1)));
  endtask

  task automatic master_b2b();
    int n, base, f, g;
    logic [23:0] a_i, a_q, b_i, b_q, c_i, c_q;
    n = 12;
    a_i = $urandom; a_q = $urandom; b_i = $urandom; b_q = $urandom; c_i = $urandom; c_q = $urandom;
    do_reset(1'b1, 4'd1, 2'b00, 2'b00);
    base = nrec;
    send(a_i, a_q);
    wait_rec(base + 4);
    send(b_i, b_q);
    send(c_i, c_q);
    wait_rec(base + 2*(2*n+2) + 8);
    f = find_fs(base);
    check(f >= 0, "R9 first frame sync", 64'(f), 64'(base));
    if (f < 0) return;
    g = f + 2*n + 2;
    check(grab(f+1, n) == exp_seq(a_i, a_q, n), "R10 first pair sent", 64'(grab(f+1, n)), 64'(exp_seq(a_i, a_q, n)));
    check(rec_fs[g] && !rec_fe[g], "R9 back-to-back sync", {rec_fs[g], rec_fe[g]}, 64'b10);
    check(grab(g+1, n) == exp_seq(c_i, c_q, n), "R10 latest pair kept", 64'(grab(g+1, n)), 64'(exp_seq(c_i, c_q, n)));
    check(!rec_fs[g+2*n+2] && !rec_fs[g+2*n+3] && !rec_sd[g+2*n+3], "R10 no frame without sample",
          {rec_fs[g+2*n+2], rec_fs[g+2*n+3], rec_sd[g+2*n+3]}, 64'd0);
  endtask

  task automatic sl_tick(input logic fsv, output logic sd, output logic fe, output logic quiet);
    fs_in = fsv; sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    sclk_in = 1'b1;
    repeat (6) @(negedge clk);
    sd = sdo; fe = fe_out; quiet = !sclk_out && !fs_out;
  endtask

  task automatic slave_frame(input logic [23:0] i, input logic [23:0] q, input logic [1:0] wl, input logic hold_fs);
    int n;
    logic sd, fe, qt, allq;
    logic [63:0] ad, afe, efe, idle;
    n = wbits(wl);
    do_reset(1'b0, 4'd0, wl, 2'b01);
    idle = '0; allq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sl_tick(1'b1, sd, fe, qt);
      idle[k] = sd | fe; allq &= qt;
    end
    check(idle == 0, "R11 sync ignored without sample", idle, 64'd0);
    send(i, q);
    ad = '0; afe = '0; efe = '0;
    for (int k = 0; k <= 2*n+2; k++) begin
      sl_tick((k == 0) || hold_fs, sd, fe, qt);
      if (k < 2*n) ad[k] = sd; else ad[k] = sd;
      afe[k] = fe; allq &= qt;
    end
    efe[2*n] = 1'b1;
    check(ad == 64'(exp_seq(i, q, n)), "R11 R4 slave data", ad, 64'(exp_seq(i, q, n)));
    check(afe == efe, "R8 slave end strobe", afe, efe);
    check(allq, "R12 slave outputs low", 64'(allq), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd7331));
    do_reset(1'b1, 4'd0, 2'b00, 2'b00);
    check(!sclk_out && !fs_out && !sdo && !fe_out, "R1 reset state",
          {sclk_out, fs_out, sdo, fe_out}, 64'd0);
    // directed corners: each word length and sync shape, extreme patterns
    master_frame(24'hFFFFFF, 24'h000000, 2'b00, 2'b00, 4'd0);
    master_frame(24'h800001, 24'hA5A5A5, 2'b01, 2'b01, 4'd2);
    master_frame(24'h123456, 24'hFEDCBA, 2'b10, 2'b10, 4'd3);
    master_frame(24'h0F0F0F, 24'hF0F0F0, 2'b11, 2'b11, 4'd1);
    master_frame(24'hC00000, 24'h800000, 2'b01, 2'b11, 4'd15);
    master_b2b();
    for (int r = 0; r < 12; r++)
      master_frame(24'($urandom), 24'($urandom), 2'($urandom % 4), 2'($urandom % 4), 4'($urandom % 4));
    slave_frame(24'h9ABCDE, 24'h13579B, 2'b00, 1'b1);
    slave_frame(24'($urandom), 24'($urandom), 2'b10, 1'b0);
    slave_frame(24'($urandom), 24'($urandom), 2'b01, 1'b1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule